// File: doc/BRIEF.md
# Priority-Class Read/Write Transaction Arbiter

This block sits between per-class transaction queues and the next scheduling stage of a storage controller. The host gives every flow one of P priority classes. Each class has one read queue and one write queue, so the block sees 2×P queue heads. Every head offers a valid flag and a payload. The block returns a one-cycle ready pulse when it takes that head's transaction.

There are two independent weighted round-robin selectors: one serves the read heads and one serves the write heads. Each selector feeds a single-entry slot. A selector picks a head only when its slot is empty, or when the consumer drains the slot in that same cycle. A shared weight input gives each class its share. A class may take up to its weight of back-to-back grants. After that, the rotation moves to the next class. Classes with no valid head are skipped in the same cycle, so no grant opportunity is lost.

Top module: `prio_rw_arbiter`

## Requirements
- R1: After reset both slots are empty, no head sees ready, and both rotation pointers rest on class 0, so the first grant with all heads valid goes to class 0.
- R2: At most one read head and at most one write head see ready in a cycle, and only a head whose valid is high can see ready.
- R3: A lane grants only when its slot is empty or its take input is high in that cycle. While the slot is full and not taken, every head of that lane sees ready low.
- R4: In the cycle after a grant, the slot is valid and holds the granted head's payload and class index. A full slot that is not taken keeps its payload and class unchanged.
- R5: With every class valid, class i receives weight field i (bits [4i+3:4i] of the weight input) consecutive grants. The rotation then moves to class i+1, wrapping from the last class to class 0, and the grant count restarts.
- R6: A class whose head is not valid is skipped in the same cycle. The grant goes to the first valid class in rotation order from the pointer, and the pointer continues from the class that was served.
- R7: A weight field of 0 behaves as a weight of 1.
- R8: The read lane and the write lane keep separate pointers and slots, and both can grant in the same cycle without affecting each other.
- R9: When the consumer takes the slot every cycle and heads stay valid, a lane moves one transaction per cycle with no empty cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| class_weight | input | NUM_CLASSES*WEIGHT_W | Weight per class, field i for class i |
| rd_head_valid | input | NUM_CLASSES | Read queue head present, one bit per class |
| rd_head_data | input | NUM_CLASSES*DATA_W | Read head payloads, field i for class i |
| rd_head_ready | output | NUM_CLASSES | Read head taken this cycle (one-hot or zero) |
| rd_slot_valid | output | 1 | Read slot holds a transaction |
| rd_slot_data | output | DATA_W | Payload in the read slot |
| rd_slot_class | output | CLASS_W | Class index of the read slot entry |
| rd_slot_take | input | 1 | Consumer drains the read slot this cycle |
| wr_head_valid | input | NUM_CLASSES | Write queue head present, one bit per class |
| wr_head_data | input | NUM_CLASSES*DATA_W | Write head payloads |
| wr_head_ready | output | NUM_CLASSES | Write head taken this cycle |
| wr_slot_valid | output | 1 | Write slot holds a transaction |
| wr_slot_data | output | DATA_W | Payload in the write slot |
| wr_slot_class | output | CLASS_W | Class index of the write slot entry |
| wr_slot_take | input | 1 | Consumer drains the write slot this cycle |

## Verification
Two things can happen in the same cycle. First, the consumer can drain a slot while the selector refills it. Second, the read and write lanes can both grant at once. The bench keeps the take inputs high while unbalanced weighted read traffic and sparse write traffic run together. The scoreboard must then see each read arrive exactly one cycle after the previous one, in the weighted order, while the write lane delivers its skip order in parallel. Separately, a full slot is held with take low, and the bench checks that the payload stays put and that no head sees ready.

// File: rtl/prio_arb_pkg.sv
// Shared helpers for the priority-class arbiter.
// Assumes class indices are small non-negative integers.
package prio_arb_pkg;

    // Index reached by stepping forward from base, modulo n.
    function automatic int wrap_add(input int base, input int step, input int n);
        int s;
        s = base + step;
        if (s >= n) s = s - n;
        return s;
    endfunction

endpackage

// File: rtl/wrr_pick.sv
// Weighted round-robin picker over NCLS requesters.
// The combinational pick is the first requester found from the pointer in
// rotation order. The pointer and grant count update only on grant_en.
// Assumes: a weight field of 0 is treated as 1.
module wrr_pick #(
    parameter int NCLS = 4,
    parameter int WW   = 4,
    localparam int IW  = (NCLS > 1) ? $clog2(NCLS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCLS-1:0]   req,
    input  logic [NCLS*WW-1:0] weights,
    input  logic              grant_en,
    output logic [IW-1:0]     pick,
    output logic              pick_ok
);
    import prio_arb_pkg::*;

    logic [IW-1:0] ptr;
    logic [WW-1:0] used;
    logic [WW-1:0] eff_w;
    logic [WW:0]   next_used;
    logic [IW-1:0] after_pick;

    // Rotating search: scan backwards so the closest valid class wins.
    always_comb begin
        pick    = ptr;
        pick_ok = 1'b0;
        for (int k = NCLS - 1; k >= 0; k--) begin
            if (req[wrap_add(int'(ptr), k, NCLS)]) begin
                pick    = IW'(wrap_add(int'(ptr), k, NCLS));
                pick_ok = 1'b1;
            end
        end
    end

    // Grant-count bookkeeping for the picked class.
    always_comb begin
        eff_w      = weights[int'(pick)*WW +: WW];
        if (eff_w == '0) eff_w = WW'(1);
        next_used  = (pick == ptr) ? {1'b0, used} + 1'b1 : (WW+1)'(1);
        after_pick = IW'(wrap_add(int'(pick), 1, NCLS));
    end

    // Pointer and count advance on each granted transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr  <= '0;
            used <= '0;
        end else if (grant_en && pick_ok) begin
            if (next_used >= {1'b0, eff_w}) begin
                ptr  <= after_pick;
                used <= '0;
            end else begin
                ptr  <= pick;
                used <= next_used[WW-1:0];
            end
        end
    end
endmodule

// File: rtl/slot_stage.sv
// Single-entry holding slot. It loads on accept and clears on take.
// Assumes: accept is asserted only while free is high.
module slot_stage #(
    parameter int DW = 16,
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic [DW-1:0] in_data,
    input  logic [CW-1:0] in_class,
    input  logic          take,
    output logic          full,
    output logic [DW-1:0] out_data,
    output logic [CW-1:0] out_class,
    output logic          free
);
    // Slot can accept when empty or being drained now.
    assign free = !full || take;

    // Occupancy and payload register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full      <= 1'b0;
            out_data  <= '0;
            out_class <= '0;
        end else if (accept) begin
            full      <= 1'b1;
            out_data  <= in_data;
            out_class <= in_class;
        end else if (take) begin
            full      <= 1'b0;
        end
    end
endmodule

// File: rtl/rw_lane.sv
// One arbitration lane: a weighted picker over the class heads feeding one slot.
// Assumes: the head data of class i sits in field i of head_data.
module rw_lane #(
    parameter int NCLS = 4,
    parameter int DW   = 16,
    parameter int WW   = 4,
    localparam int CW  = (NCLS > 1) ? $clog2(NCLS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NCLS*WW-1:0] weights,
    input  logic [NCLS-1:0]    head_valid,
    input  logic [NCLS*DW-1:0] head_data,
    output logic [NCLS-1:0]    head_ready,
    output logic               slot_valid,
    output logic [DW-1:0]      slot_data,
    output logic [CW-1:0]      slot_class,
    input  logic               slot_take
);
    logic [CW-1:0] pick;
    logic          pick_ok;
    logic          free;
    logic          accept;
    logic [DW-1:0] sel_data;

    wrr_pick #(.NCLS(NCLS), .WW(WW)) u_pick (
        .clk(clk), .rst_n(rst_n), .req(head_valid), .weights(weights),
        .grant_en(free), .pick(pick), .pick_ok(pick_ok)
    );

    // Grant happens when a head is valid and the slot has room.
    assign accept   = free && pick_ok;
    assign sel_data = head_data[int'(pick)*DW +: DW];

    // One-hot ready back to the granted head.
    always_comb begin
        head_ready = '0;
        if (accept) head_ready[pick] = 1'b1;
    end

    slot_stage #(.DW(DW), .CW(CW)) u_slot (
        .clk(clk), .rst_n(rst_n), .accept(accept), .in_data(sel_data),
        .in_class(pick), .take(slot_take), .full(slot_valid),
        .out_data(slot_data), .out_class(slot_class), .free(free)
    );
endmodule

// File: rtl/prio_rw_arbiter.sv
// Top: separate weighted round-robin lanes for read heads and write heads.
// Each lane fills its own single-entry slot. The weights are shared per class.
// Assumes: a queue head holds its payload steady until its ready pulse.
module prio_rw_arbiter #(
    parameter int NUM_CLASSES = 4,
    parameter int DATA_W      = 16,
    parameter int WEIGHT_W    = 4,
    localparam int CLASS_W    = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CLASSES*WEIGHT_W-1:0] class_weight,
    input  logic [NUM_CLASSES-1:0]        rd_head_valid,
    input  logic [NUM_CLASSES*DATA_W-1:0] rd_head_data,
    output logic [NUM_CLASSES-1:0]        rd_head_ready,
    output logic                          rd_slot_valid,
    output logic [DATA_W-1:0]             rd_slot_data,
    output logic [CLASS_W-1:0]            rd_slot_class,
    input  logic                          rd_slot_take,
    input  logic [NUM_CLASSES-1:0]        wr_head_valid,
    input  logic [NUM_CLASSES*DATA_W-1:0] wr_head_data,
    output logic [NUM_CLASSES-1:0]        wr_head_ready,
    output logic                          wr_slot_valid,
    output logic [DATA_W-1:0]             wr_slot_data,
    output logic [CLASS_W-1:0]            wr_slot_class,
    input  logic                          wr_slot_take
);
    rw_lane #(.NCLS(NUM_CLASSES), .DW(DATA_W), .WW(WEIGHT_W)) u_rd_lane (
        .clk(clk), .rst_n(rst_n), .weights(class_weight),
        .head_valid(rd_head_valid), .head_data(rd_head_data),
        .head_ready(rd_head_ready), .slot_valid(rd_slot_valid),
        .slot_data(rd_slot_data), .slot_class(rd_slot_class),
        .slot_take(rd_slot_take)
    );

    rw_lane #(.NCLS(NUM_CLASSES), .DW(DATA_W), .WW(WEIGHT_W)) u_wr_lane (
        .clk(clk), .rst_n(rst_n), .weights(class_weight),
        .head_valid(wr_head_valid), .head_data(wr_head_data),
        .head_ready(wr_head_ready), .slot_valid(wr_slot_valid),
        .slot_data(wr_slot_data), .slot_class(wr_slot_class),
        .slot_take(wr_slot_take)
    );
endmodule

// File: rtl/prio_rw_arbiter_chk.sv
// Property checker for prio_rw_arbiter, attached by bind below.
// Observes ports only.
module prio_rw_arbiter_chk #(
    parameter int NUM_CLASSES = 4,
    parameter int DATA_W      = 16,
    localparam int CLASS_W    = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NUM_CLASSES-1:0] rd_head_valid,
    input logic [NUM_CLASSES-1:0] rd_head_ready,
    input logic                   rd_slot_valid,
    input logic [DATA_W-1:0]      rd_slot_data,
    input logic [CLASS_W-1:0]     rd_slot_class,
    input logic                   rd_slot_take,
    input logic [NUM_CLASSES-1:0] wr_head_valid,
    input logic [NUM_CLASSES-1:0] wr_head_ready,
    input logic                   wr_slot_valid,
    input logic [DATA_W-1:0]      wr_slot_data,
    input logic [CLASS_W-1:0]     wr_slot_class,
    input logic                   wr_slot_take
);
    // R2
    rd_ready_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_head_ready));
    // R2
    wr_ready_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_head_ready));
    // R2
    rd_ready_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_head_ready & ~rd_head_valid) == '0);
    // R2
    wr_ready_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_head_ready & ~wr_head_valid) == '0);
    // R3
    rd_full_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_slot_valid && !rd_slot_take) |-> (rd_head_ready == '0));
    // R3
    wr_full_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_slot_valid && !wr_slot_take) |-> (wr_head_ready == '0));
    // R4
    rd_load_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_head_ready != '0) |=>
        (rd_slot_valid && ((NUM_CLASSES'(1) << rd_slot_class) == $past(rd_head_ready))));
    // R4
    wr_load_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_head_ready != '0) |=>
        (wr_slot_valid && ((NUM_CLASSES'(1) << wr_slot_class) == $past(wr_head_ready))));
    // R4
    rd_hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_slot_valid && !rd_slot_take) |=>
        (rd_slot_valid && $stable(rd_slot_data) && $stable(rd_slot_class)));
    // R4
    wr_hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_slot_valid && !wr_slot_take) |=>
        (wr_slot_valid && $stable(wr_slot_data) && $stable(wr_slot_class)));
endmodule

bind prio_rw_arbiter prio_rw_arbiter_chk #(
    .NUM_CLASSES(NUM_CLASSES), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .rd_head_valid(rd_head_valid), .rd_head_ready(rd_head_ready),
    .rd_slot_valid(rd_slot_valid), .rd_slot_data(rd_slot_data),
    .rd_slot_class(rd_slot_class), .rd_slot_take(rd_slot_take),
    .wr_head_valid(wr_head_valid), .wr_head_ready(wr_head_ready),
    .wr_slot_valid(wr_slot_valid), .wr_slot_data(wr_slot_data),
    .wr_slot_class(wr_slot_class), .wr_slot_take(wr_slot_take)
);

// File: tb/prio_rw_arbiter_bench.sv
// Scoreboard bench: tasks load the class queues and push the expected order.
// The monitor task pops and compares each slot entry as it is taken.
module prio_rw_arbiter_bench;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int P  = 4;
    localparam int DW = 16;
    localparam int WW = 4;
    localparam int QD = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [P*WW-1:0] class_weight = '0;
    logic [P-1:0]    rd_head_valid = '0, wr_head_valid = '0;
    logic [P*DW-1:0] rd_head_data = '0, wr_head_data = '0;
    logic [P-1:0]    rd_head_ready, wr_head_ready;
    logic            rd_slot_valid, wr_slot_valid;
    logic [DW-1:0]   rd_slot_data, wr_slot_data;
    logic [1:0]      rd_slot_class, wr_slot_class;
    logic            rd_slot_take = 1'b0, wr_slot_take = 1'b0;

    always #2.5 clk = ~clk;

    prio_rw_arbiter #(.NUM_CLASSES(P), .DATA_W(DW), .WEIGHT_W(WW)) u_prio_rw_arbiter (
        .clk(clk), .rst_n(rst_n), .class_weight(class_weight),
        .rd_head_valid(rd_head_valid), .rd_head_data(rd_head_data),
        .rd_head_ready(rd_head_ready), .rd_slot_valid(rd_slot_valid),
        .rd_slot_data(rd_slot_data), .rd_slot_class(rd_slot_class),
        .rd_slot_take(rd_slot_take),
        .wr_head_valid(wr_head_valid), .wr_head_data(wr_head_data),
        .wr_head_ready(wr_head_ready), .wr_slot_valid(wr_slot_valid),
        .wr_slot_data(wr_slot_data), .wr_slot_class(wr_slot_class),
        .wr_slot_take(wr_slot_take)
    );

    int checks = 0, failures = 0, cyc = 0;
    logic [DW-1:0] hbuf [2][P][QD];
    int hhead [2][P];
    int htail [2][P];
    logic [DW-1:0] exq [2][64];
    int exh [2];
    int ext [2];
    int rcv_n [2];
    int rcv_first [2];
    int rcv_last [2];
    logic [1:0] take_en = 2'b00;
    string tag_now = "R5";

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_all();
        for (int k = 0; k < 2; k++) begin
            exh[k] = 0; ext[k] = 0; rcv_n[k] = 0; rcv_first[k] = 0; rcv_last[k] = 0;
            for (int c = 0; c < P; c++) begin hhead[k][c] = 0; htail[k][c] = 0; end
        end
    endtask

    // Driver: queue an item at class c of lane k and record it as expected next.
    task automatic push(input int k, input int c);
        logic [DW-1:0] item;
        item = {4'(k), 4'(c), 8'(ext[k])};
        hbuf[k][c][htail[k][c]] = item;
        htail[k][c]++;
        exq[k][ext[k]] = item;
        ext[k]++;
    endtask

    // Monitor: compare a slot entry that the consumer takes this cycle.
    task automatic monitor(input int k);
        logic sv;
        logic [DW-1:0] sd;
        logic [1:0] sc;
        sv = (k == 0) ? rd_slot_valid : wr_slot_valid;
        sd = (k == 0) ? rd_slot_data : wr_slot_data;
        sc = (k == 0) ? rd_slot_class : wr_slot_class;
        if (take_en[k] && sv) begin
            if (exh[k] == ext[k]) begin
                check(1'b0, {tag_now, " unexpected entry"}, int'(sd), 0);
            end else begin
                check(sd == exq[k][exh[k]], {tag_now, " order"}, int'(sd), int'(exq[k][exh[k]]));
                check(int'(sc) == int'(exq[k][exh[k]][11:8]), "R4 class tag",
                      int'(sc), int'(exq[k][exh[k]][11:8]));
                exh[k]++;
            end
            if (rcv_n[k] == 0) rcv_first[k] = cyc;
            rcv_last[k] = cyc;
            rcv_n[k]++;
        end
    endtask

    task automatic cycle();
        logic [P-1:0] rdy [2];
        @(negedge clk);
        monitor(0);
        monitor(1);
        rd_slot_take = take_en[0];
        wr_slot_take = take_en[1];
        for (int c = 0; c < P; c++) begin
            rd_head_valid[c] = hhead[0][c] != htail[0][c];
            wr_head_valid[c] = hhead[1][c] != htail[1][c];
            rd_head_data[c*DW +: DW] = hbuf[0][c][hhead[0][c]];
            wr_head_data[c*DW +: DW] = hbuf[1][c][hhead[1][c]];
        end
        #1;
        rdy[0] = rd_head_ready;
        rdy[1] = wr_head_ready;
        @(posedge clk);
        for (int c = 0; c < P; c++) begin
            if (rdy[0][c]) hhead[0][c]++;
            if (rdy[1][c]) hhead[1][c]++;
        end
        cyc++;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        take_en = 2'b00;
        rd_slot_take = 1'b0; wr_slot_take = 1'b0;
        rd_head_valid = '0; wr_head_valid = '0;
        clear_all();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int rd_order [14] = '{0, 0, 1, 2, 2, 2, 3, 0, 0, 1, 2, 2, 2, 3};
        int wr_order [4]  = '{1, 3, 1, 3};
        do_reset();
        // R1: empty slots, no ready after reset
        @(negedge clk);
        check(rd_slot_valid == 1'b0, "R1 rd slot empty", int'(rd_slot_valid), 0);
        check(wr_slot_valid == 1'b0, "R1 wr slot empty", int'(wr_slot_valid), 0);
        check(rd_head_ready == '0, "R1 no ready", int'(rd_head_ready), 0);

        // R5 + R1 read weights 2,1,3,1; R6 + R8 sparse writes in parallel; R9 throughput
        class_weight = {4'd1, 4'd3, 4'd1, 4'd2};
        foreach (rd_order[i]) push(0, rd_order[i]);
        foreach (wr_order[i]) push(1, wr_order[i]);
        take_en = 2'b11;
        tag_now = "R5/R6";
        repeat (18) cycle();
        check(exh[0] == ext[0], "R5 all reads delivered", exh[0], ext[0]);
        check(exh[1] == ext[1], "R6 all writes delivered", exh[1], ext[1]);
        check(rcv_last[0] - rcv_first[0] == 13, "R9 one read per cycle",
              rcv_last[0] - rcv_first[0], 13);
        check(rcv_first[0] == rcv_first[1], "R8 lanes grant together",
              rcv_first[1], rcv_first[0]);

        // R3/R4: full slot held with take low
        do_reset();
        class_weight = {4'd1, 4'd1, 4'd1, 4'd1};
        push(0, 2);
        push(0, 2);
        tag_now = "R4";
        repeat (3) cycle();
        #2;
        check(rd_slot_valid == 1'b1, "R4 slot loaded", int'(rd_slot_valid), 1);
        check(rd_slot_data == exq[0][0], "R4 slot holds first item", int'(rd_slot_data), int'(exq[0][0]));
        check(rd_slot_class == 2'd2, "R4 slot class", int'(rd_slot_class), 2);
        check(rd_head_ready == '0, "R3 no grant while full", int'(rd_head_ready), 0);
        check(hhead[0][2] == 1, "R3 second item still queued", hhead[0][2], 1);
        take_en = 2'b01;
        repeat (4) cycle();
        check(exh[0] == 2, "R3 drain delivers both", exh[0], 2);

        // R7: zero weights act as one
        do_reset();
        class_weight = {4'd1, 4'd0, 4'd1, 4'd0};
        for (int r = 0; r < 2; r++) for (int c = 0; c < P; c++) push(0, c);
        take_en = 2'b01;
        tag_now = "R7";
        repeat (11) cycle();
        check(exh[0] == 8, "R7 all delivered", exh[0], 8);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule